// File: doc/BRIEF.md
# Linked Command List Engine

This block is the command unit of a descriptor-driven network controller. Software first points the unit at a memory region with a load-base opcode. A start opcode then hands it the offset of the first command block. From there the engine walks a chain of blocks through a single 32-bit word port that uses a request/acknowledge handshake. For each block it reads the control word and the link word. It carries out a stub action: a transmit command bumps a frame counter, and every other command does nothing. It then writes the control word back with the completion and success flags set.

After each block the engine picks one of three outcomes. It can stop in the idle state, park in the suspended state, or follow the link to the next block. A resume opcode can release a parked list, but only once the parked block's suspend flag has been cleared in memory. Events go out as single-cycle pulses: one for a command that asked for an interrupt, and one for the unit leaving the active state. Opcodes presented while the engine is walking are dropped.

Top module: `cmdu_engine`

## Requirements
- R1: After reset `unit_state` is 0 (idle), `busy` is 0, `mem_req` is 0, both event outputs are 0 and `tx_count` is 0.
- R2: Opcode 6 loads `gen_ptr` into the base register. Opcode 1 loads `gen_ptr` into the current offset, sets `unit_state` to 2 (low-priority active) and starts walking. A block lives at base plus offset: its control word is at that byte address and its link offset is at that address plus 4.
- R3: For every block, the engine reads the control word and then the link word, and then writes the control word with bit 15 (complete) and bit 13 (ok) set back to the block address.
- R4: If bit 29 of a block's control word is set, `evt_cmd_done` pulses for one cycle when that block's write-back completes. Otherwise it stays low.
- R5: If bit 31 of the control word is set, the unit returns to state 0 (idle) after the write-back, `evt_left_active` pulses once and `busy` falls. This takes priority over bit 30.
- R6: If bit 31 is clear and bit 30 is set, the unit enters state 1 (suspended), `evt_left_active` pulses once and `busy` falls.
- R7: If bits 31 and 30 are both clear, the current offset becomes the block's link offset and the next block is processed at base plus link.
- R8: The command field is bits 18:16 of the control word. Value 4 (transmit) adds one to `tx_count`. Every other value, including unsupported ones such as 7, completes with the ok flag and leaves `tx_count` unchanged.
- R9: Opcode 2 (resume) in state 0 is ignored: no memory access is made and the state stays 0.
- R10: Resume in state 1 reads only the control word at the current offset. If bit 30 of that word is still set, the unit stays suspended with no write and no event.
- R11: Resume in state 1 with bit 30 clear reads the link word, moves the current offset to it, enters state 2 and processes the block at base plus link. The parked block is not written again.
- R12: While `busy` is 1, every opcode is ignored, including load-base and start. Opcodes other than 0, 1, 2 and 6 are ignored at all times.
- R13: `mem_req` is held high with `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack`. Each acknowledged request is exactly one word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Opcode strobe, one cycle |
| op_code | input | 4 | Opcode: 0 nop, 1 start, 2 resume, 6 load base |
| gen_ptr | input | AW | General pointer operand for start and load base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Engine is walking or checking a resume |
| unit_state | output | 2 | 0 idle, 1 suspended, 2 low-priority active, 3 high-priority active (unused) |
| evt_cmd_done | output | 1 | Pulse: a block with the interrupt bit finished |
| evt_left_active | output | 1 | Pulse: the unit entered idle or suspended |
| tx_count | output | CNT_W | Count of transmit commands executed |

## Verification
The hardest situation to reach is a resume that meets a parked block whose suspend flag is still set, followed by a second resume after that flag is cleared. The bench first parks the unit with a suspending block. It then issues resume against the unchanged write-back word and counts memory accesses to show that only one read took place. Next it rewrites the stored control word in its memory model and resumes again. Dropping opcodes while busy needs a long memory latency, which the bench sets so that load-base and start arrive in the middle of a walk. It then shows their absence through the write-back address of a later walk.

// File: rtl/cmdu_pkg.sv
package cmdu_pkg;

  localparam int WORD_W  = 32;
  localparam int CTL_END = 31;  // end of list
  localparam int CTL_SUS = 30;  // suspend after block
  localparam int CTL_IRQ = 29;  // raise command-done event
  localparam int CTL_CMP = 15;  // completion flag written back
  localparam int CTL_OK  = 13;  // success flag written back
  localparam int CMD_LSB = 16;
  localparam int CMD_W   = 3;

  typedef enum logic [1:0] {
    UNIT_IDLE  = 2'd0,
    UNIT_SUSP  = 2'd1,
    UNIT_LOACT = 2'd2,
    UNIT_HIACT = 2'd3
  } unit_e;

  typedef enum logic [3:0] {
    OPC_NOP    = 4'd0,
    OPC_START  = 4'd1,
    OPC_RESUME = 4'd2,
    OPC_LDBASE = 4'd6
  } opc_e;

  typedef enum logic [CMD_W-1:0] {
    BLK_NOP   = 3'd0,
    BLK_ADDR  = 3'd1,
    BLK_CFG   = 3'd2,
    BLK_TX    = 3'd4,
    BLK_UCODE = 3'd5
  } blk_cmd_e;

  typedef enum logic [2:0] {
    SQ_WAIT,
    SQ_RD_CTRL,
    SQ_RD_LINK,
    SQ_WB,
    SQ_RS_CTRL,
    SQ_RS_LINK
  } seq_e;

  typedef struct packed {
    logic last;
    logic susp;
    logic irq;
    logic tx;
  } ctl_t;

endpackage

// File: rtl/cmdu_ctl_decode.sv
module cmdu_ctl_decode
  import cmdu_pkg::*;
(
  input  logic [WORD_W-1:0] ctl_word,
  output ctl_t              fields,
  output logic [WORD_W-1:0] wb_word
);

  logic [CMD_W-1:0] cmd;

  always_comb begin
    cmd         = ctl_word[CMD_LSB +: CMD_W];
    fields.last = ctl_word[CTL_END];
    fields.susp = ctl_word[CTL_SUS];
    fields.irq  = ctl_word[CTL_IRQ];
    fields.tx   = (cmd == BLK_TX);
    wb_word          = ctl_word;
    wb_word[CTL_CMP] = 1'b1;
    wb_word[CTL_OK]  = 1'b1;
  end

endmodule

// File: rtl/cmdu_mem_port.sv
module cmdu_mem_port
  import cmdu_pkg::*;
#(
  parameter int AW = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [AW-1:0]     start_addr,
  input  logic [WORD_W-1:0] start_wdata,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              done
);

  logic              req_q, req_d;
  logic              we_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              load_en;

  always_comb begin
    load_en = !req_q && start;
    req_d   = req_q;
    if (req_q && mem_ack) req_d = 1'b0;
    else if (load_en)     req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      req_q <= req_d;
      if (load_en) begin
        we_q    <= start_we;
        addr_q  <= start_addr;
        wdata_q <= start_wdata;
      end
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign done      = req_q && mem_ack;

  a_r13_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

endmodule

// File: rtl/cmdu_walker.sv
module cmdu_walker
  import cmdu_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [AW-1:0]     gen_ptr,
  input  logic              acc_done,
  input  logic              acc_pending,
  input  logic [WORD_W-1:0] acc_rdata,
  output logic              acc_start,
  output logic              acc_we,
  output logic [AW-1:0]     acc_addr,
  output logic [WORD_W-1:0] acc_wdata,
  output logic              busy,
  output logic [1:0]        unit_state,
  output logic              evt_done,
  output logic              evt_left,
  output logic [CNT_W-1:0]  tx_count
);

  localparam logic [AW-1:0]    LINK_OFS = AW'(4);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  seq_e              sq_q, sq_d;
  unit_e             unit_q, unit_d;
  logic [AW-1:0]     base_q, base_d;
  logic [AW-1:0]     off_q, off_d;
  logic [AW-1:0]     link_q, link_d;
  logic [WORD_W-1:0] ctl_q, ctl_d;
  logic [CNT_W-1:0]  tx_q, tx_d;
  logic              evd_q, evd_d;
  logic              evl_q, evl_d;
  logic [AW-1:0]     blk_addr;
  ctl_t              fields;
  logic [WORD_W-1:0] wb_word;

  cmdu_ctl_decode u_dec (
    .ctl_word (ctl_q),
    .fields   (fields),
    .wb_word  (wb_word)
  );

  // next-state
  always_comb begin
    sq_d   = sq_q;
    unit_d = unit_q;
    base_d = base_q;
    off_d  = off_q;
    link_d = link_q;
    ctl_d  = ctl_q;
    tx_d   = tx_q;
    evd_d  = 1'b0;
    evl_d  = 1'b0;
    unique case (sq_q)
      SQ_WAIT: begin
        if (op_valid) begin
          if (op_code == OPC_START) begin
            off_d  = gen_ptr;
            unit_d = UNIT_LOACT;
            sq_d   = SQ_RD_CTRL;
          end else if (op_code == OPC_RESUME) begin
            if (unit_q != UNIT_IDLE) sq_d = SQ_RS_CTRL;
          end else if (op_code == OPC_LDBASE) begin
            base_d = gen_ptr;
          end
        end
      end
      SQ_RD_CTRL: if (acc_done) begin
        ctl_d = acc_rdata;
        sq_d  = SQ_RD_LINK;
      end
      SQ_RD_LINK: if (acc_done) begin
        link_d = acc_rdata[AW-1:0];
        sq_d   = SQ_WB;
      end
      SQ_WB: if (acc_done) begin
        if (fields.tx) tx_d = tx_q + CNT_ONE;
        evd_d = fields.irq;
        if (fields.last) begin
          unit_d = UNIT_IDLE;
          evl_d  = 1'b1;
          sq_d   = SQ_WAIT;
        end else if (fields.susp) begin
          unit_d = UNIT_SUSP;
          evl_d  = 1'b1;
          sq_d   = SQ_WAIT;
        end else begin
          off_d = link_q;
          sq_d  = SQ_RD_CTRL;
        end
      end
      SQ_RS_CTRL: if (acc_done) begin
        ctl_d = acc_rdata;
        sq_d  = acc_rdata[CTL_SUS] ? SQ_WAIT : SQ_RS_LINK;
      end
      SQ_RS_LINK: if (acc_done) begin
        off_d  = acc_rdata[AW-1:0];
        unit_d = UNIT_LOACT;
        sq_d   = SQ_RD_CTRL;
      end
      default: sq_d = SQ_WAIT;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q   <= SQ_WAIT;
      unit_q <= UNIT_IDLE;
      base_q <= '0;
      off_q  <= '0;
      link_q <= '0;
      ctl_q  <= '0;
      tx_q   <= '0;
      evd_q  <= 1'b0;
      evl_q  <= 1'b0;
    end else begin
      sq_q   <= sq_d;
      unit_q <= unit_d;
      base_q <= base_d;
      off_q  <= off_d;
      link_q <= link_d;
      ctl_q  <= ctl_d;
      tx_q   <= tx_d;
      evd_q  <= evd_d;
      evl_q  <= evl_d;
    end
  end

  always_comb begin
    blk_addr  = base_q + off_q;
    busy      = (sq_q != SQ_WAIT);
    acc_start = busy && !acc_pending;
    acc_we    = (sq_q == SQ_WB);
    acc_addr  = ((sq_q == SQ_RD_LINK) || (sq_q == SQ_RS_LINK)) ? blk_addr + LINK_OFS
                                                               : blk_addr;
    acc_wdata = wb_word;
  end

  assign unit_state = unit_q;
  assign evt_done   = evd_q;
  assign evt_left   = evl_q;
  assign tx_count   = tx_q;

  a_r4_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    evd_q |-> $past(sq_q == SQ_WB && acc_done));

  a_r5_left_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    evl_q |-> ((unit_q == UNIT_IDLE || unit_q == UNIT_SUSP) && sq_q == SQ_WAIT));

  a_r12_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_q != SQ_WAIT) |=> $stable(base_q));

  a_r10_refused_stays_susp: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_q == SQ_RS_CTRL && acc_done && acc_rdata[CTL_SUS]) |=>
      (unit_q == UNIT_SUSP && !evl_q));

endmodule

// File: rtl/cmdu_engine.sv
module cmdu_engine
  import cmdu_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [AW-1:0]     gen_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic [1:0]        unit_state,
  output logic              evt_cmd_done,
  output logic              evt_left_active,
  output logic [CNT_W-1:0]  tx_count
);

  logic              acc_start, acc_we, acc_done;
  logic [AW-1:0]     acc_addr;
  logic [WORD_W-1:0] acc_wdata;

  cmdu_walker #(.AW(AW), .CNT_W(CNT_W)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .gen_ptr     (gen_ptr),
    .acc_done    (acc_done),
    .acc_pending (mem_req),
    .acc_rdata   (mem_rdata),
    .acc_start   (acc_start),
    .acc_we      (acc_we),
    .acc_addr    (acc_addr),
    .acc_wdata   (acc_wdata),
    .busy        (busy),
    .unit_state  (unit_state),
    .evt_done    (evt_cmd_done),
    .evt_left    (evt_left_active),
    .tx_count    (tx_count)
  );

  cmdu_mem_port #(.AW(AW)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (acc_start),
    .start_we    (acc_we),
    .start_addr  (acc_addr),
    .start_wdata (acc_wdata),
    .mem_ack     (mem_ack),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .done        (acc_done)
  );

  a_r3_wb_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[CTL_CMP] && mem_wdata[CTL_OK]));

  a_r12_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r1_unit_range: assert property (@(posedge clk) disable iff (!rst_n)
    unit_state != UNIT_HIACT);

endmodule

// File: tb/test_cmdu_engine.sv
module test_cmdu_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [31:0] gen_ptr;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, evt_cmd_done, evt_left_active;
  logic [1:0]  unit_state;
  logic [15:0] tx_count;

  always #2.5 clk = ~clk;

  cmdu_engine i_cmdu_engine (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .gen_ptr(gen_ptr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .unit_state(unit_state), .evt_cmd_done(evt_cmd_done),
    .evt_left_active(evt_left_active), .tx_count(tx_count)
  );

  // memory model
  logic [31:0] mem [256];
  int          lat, wait_cnt, n_acc, n_done, n_left;
  logic [31:0] last_wr;
  int          checks = 0, fails = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack  <= 1'b0;
      wait_cnt = 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wait_cnt >= lat) begin
          wait_cnt = 0;
          mem_ack   <= 1'b1;
          mem_rdata <= mem[mem_addr[9:2]];
          if (mem_we) begin
            mem[mem_addr[9:2]] = mem_wdata;
            last_wr = mem_addr;
          end
          n_acc++;
        end else wait_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && evt_cmd_done)    n_done++;
    if (rst_n && evt_left_active) n_left++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue_op(input logic [3:0] code, input logic [31:0] ptr);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; gen_ptr = ptr;
    @(negedge clk);
    op_valid = 1'b0; op_code = 4'd0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // {control word, expected state, expected done event, expected tx increment}
  localparam logic [35:0] VEC [6] = '{
    {32'h8000_0000, 2'd0, 1'b0, 1'b0},  // end of list, nop
    {32'hA004_0000, 2'd0, 1'b1, 1'b1},  // end + irq + transmit
    {32'h4001_0000, 2'd1, 1'b0, 1'b0},  // suspend, address setup
    {32'h6005_0000, 2'd1, 1'b1, 1'b0},  // suspend + irq, microcode
    {32'h2004_0000, 2'd0, 1'b1, 1'b1},  // continue to second block
    {32'hC007_0000, 2'd0, 1'b0, 1'b0}   // end wins over suspend, unsupported cmd
  };

  initial begin
    int a0, d0, l0, t0;
    rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; gen_ptr = '0;
    lat = 1; n_acc = 0; n_done = 0; n_left = 0; last_wr = '0;
    for (int k = 0; k < 256; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 state", {30'd0, unit_state}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 req", {31'd0, mem_req}, 32'd0);
    chk("R1 events", {30'd0, evt_cmd_done, evt_left_active}, 32'd0);
    chk("R1 tx_count", {16'd0, tx_count}, 32'd0);

    issue_op(4'd6, 32'h100);

    for (int i = 0; i < 6; i++) begin
      mem[80] = VEC[i][35:4]; mem[81] = 32'h80;
      mem[96] = 32'h8000_0000; mem[97] = 32'h0;
      a0 = n_acc; d0 = n_done; l0 = n_left; t0 = tx_count;
      issue_op(4'd1, 32'h40);
      wait_idle();
      chk($sformatf("R5/R6 state v%0d", i), {30'd0, unit_state}, {30'd0, VEC[i][3:2]});
      chk($sformatf("R3 writeback v%0d", i), mem[80], VEC[i][35:4] | 32'h0000_A000);
      chk($sformatf("R4 done events v%0d", i), n_done - d0, {31'd0, VEC[i][1]});
      chk($sformatf("R5 left events v%0d", i), n_left - l0, 32'd1);
      chk($sformatf("R8 tx delta v%0d", i), tx_count - t0, {31'd0, VEC[i][0]});
      if (VEC[i][35:34] == 2'b00) begin
        chk($sformatf("R7 second block v%0d", i), mem[96], 32'h8000_A000);
        chk($sformatf("R7 accesses v%0d", i), n_acc - a0, 32'd6);
      end else if (i == 0) begin
        chk("R2 block address", last_wr, 32'h140);
        chk("R13 one access per ack", n_acc - a0, 32'd3);
      end
    end

    // resume in idle
    a0 = n_acc;
    issue_op(4'd2, 32'h0);
    repeat (4) @(negedge clk);
    chk("R9 no access", n_acc - a0, 32'd0);
    chk("R9 state", {30'd0, unit_state}, 32'd0);

    // park with slow memory
    lat = 3;
    mem[80] = 32'h4000_0000; mem[81] = 32'hC0;
    a0 = n_acc;
    issue_op(4'd1, 32'h40);
    wait_idle();
    chk("R6 parked", {30'd0, unit_state}, 32'd1);
    chk("R13 accesses slow memory", n_acc - a0, 32'd3);

    // resume refused: suspend bit still set
    a0 = n_acc; l0 = n_left;
    issue_op(4'd2, 32'h0);
    wait_idle();
    chk("R10 state", {30'd0, unit_state}, 32'd1);
    chk("R10 single read", n_acc - a0, 32'd1);
    chk("R10 no event", n_left - l0, 32'd0);

    // resume accepted
    mem[80] = 32'h0000_A000;
    mem[112] = 32'h8004_0000; mem[113] = 32'h0;
    a0 = n_acc; t0 = tx_count;
    issue_op(4'd2, 32'h0);
    wait_idle();
    chk("R11 state", {30'd0, unit_state}, 32'd0);
    chk("R11 linked block written", mem[112], 32'h8004_A000);
    chk("R11 parked block untouched", mem[80], 32'h0000_A000);
    chk("R11 tx", tx_count - t0, 32'd1);
    chk("R11 accesses", n_acc - a0, 32'd5);

    // opcodes during busy
    lat = 6;
    mem[80] = 32'h8000_0000; mem[144] = 32'h8000_0000;
    a0 = n_acc;
    issue_op(4'd1, 32'h40);
    issue_op(4'd6, 32'h200);
    issue_op(4'd1, 32'h40);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R12 second start dropped", n_acc - a0, 32'd3);
    lat = 1;
    mem[80] = 32'h8004_0000;
    issue_op(4'd1, 32'h40);
    wait_idle();
    chk("R12 base unchanged", mem[80], 32'h8004_A000);
    chk("R12 other block untouched", mem[144], 32'h8000_0000);
    chk("R2 address after base test", last_wr, 32'h140);
    a0 = n_acc;
    issue_op(4'd5, 32'h300);
    issue_op(4'd0, 32'h300);
    repeat (4) @(negedge clk);
    chk("R12 unknown opcode", n_acc - a0, 32'd0);
    chk("R12 unknown opcode busy", {31'd0, busy}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule